// File: doc/BRIEF.md
# Parallel Distributed-Arithmetic FIR Filter with Shared Coefficient Tables

This block is a runtime-reprogrammable FIR filter. It accepts one unsigned sample per clock and returns one full-precision result per clock. It needs no multiplier. The taps are split into groups of `TAPS_PER_GRP` neighbours. For each group, a small bank of registers holds every nonzero subset sum of that group's coefficients. The empty subset is a hard-wired zero and is not stored.

Every bit position of the input word has its own multiplexer into that group's bank. All bit weights are therefore looked up in the same cycle, and there is only one copy of the table. For each bit weight, a pipelined adder tree sums the group lookups. A pipelined shift-add tree then scales each bit weight by its power of two and combines them.

A new coefficient set is presented on a wide parallel bus together with a one-cycle load strobe. All group tables are rewritten on that edge, and the subset sums are formed by adders as the set is loaded. A valid flag travels with each accepted sample. It rises on the output a fixed number of cycles later. Signed streams are expected to be offset into the unsigned range before they reach the block.

Top module: `da_fir_shared_lut`

## Requirements
- R1: While reset is asserted, and after it for as long as no sample has been accepted, `outValid` is 0 and `yOut` is 0.
- R2: Each cycle with `inValid` high produces exactly one cycle of `outValid` high, exactly 7 clock edges after the edge that accepts the sample (default parameters). Back-to-back samples give back-to-back results.
- R3: The result for a sample is y = sum over k of h(k)·x(n−k), for k = 0..15. Here x(n) is the sample just accepted and x(n−k) is the k-th earlier accepted sample, with 0 for samples not yet received. Coefficient h(k) is the unsigned value on `coefIn[k*8 +: 8]`, and all samples are unsigned.
- R4: A cycle with `inValid` low does not move the delay line. The value on `inSample` in that cycle does not enter any later result.
- R5: A load (`coefLoad` high) takes effect for the sample accepted in the same cycle and for every later sample. Samples accepted before the load still complete with the old set. `coefIn` is ignored in cycles without the strobe.
- R6: The result is full precision, 20 bits. With all coefficients and all samples at 255 the result is 1040400, and no result ever exceeds that value.
- R7: Each group table resolves all four select patterns of a tap pair: none set, even tap only, odd tap only, both taps. A single nonzero sample followed by zeros therefore yields each coefficient times that sample, in tap order.
- R8: When the loaded coefficient set is all zero, every result from the 7th edge after the load onward is 0, whatever the samples are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Accepts `inSample` on this edge |
| inSample | input | 8 | Unsigned input sample |
| coefLoad | input | 1 | Load strobe for the coefficient bus |
| coefIn | input | 128 | Coefficient k at bits [k*8 +: 8], unsigned |
| outValid | output | 1 | `yOut` holds the result for an accepted sample |
| yOut | output | 20 | Full-precision filter result |

## Verification
If one register in a group table is wrong, the error reaches the output 7 edges after the load. It then shows only on results whose sample bits hit that table entry. This is why the bench mixes impulses, saturated inputs and random data, so that every select pattern is exercised. A wrong delay-line shift or a wrong bit-slice weight corrupts the very first result that depends on it. A broken valid pipeline shows as a result that arrives in the wrong cycle, or one that is missing or extra. The bench tracks the expected arrival cycle of every result, so that fault is caught at once.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // advance delay line with the new sample
    logic loadTbl;   // rewrite all subset-sum tables
  } dpStrobe_t;
endpackage

// File: rtl/da_add_tree.sv
// Registered binary tree, heap ordered: node 1 is the root, leaves sit at
// COUNT..2*COUNT-1. With WEIGHTED set, leaf i carries weight 2^i.
module da_add_tree #(
  parameter int COUNT    = 8,
  parameter int IN_W     = 9,
  parameter int OUT_W    = 12,
  parameter int WEIGHTED = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [COUNT*IN_W-1:0] leafIn,
  output logic [OUT_W-1:0]      rootOut
);
  localparam int LEVELS = $clog2(COUNT);

  logic [OUT_W-1:0] leaf [COUNT];
  logic [OUT_W-1:0] node [1:COUNT-1];

  for (genvar i = 0; i < COUNT; i++) begin : lf
    assign leaf[i] = OUT_W'(leafIn[i*IN_W +: IN_W]);
  end

  for (genvar d = 0; d < LEVELS; d++) begin : lvl
    for (genvar k = 0; k < (1 << d); k++) begin : nd
      localparam int J  = (1 << d) + k;
      localparam int SH = (WEIGHTED != 0) ? (COUNT >> (d + 1)) : 0;
      logic [OUT_W-1:0] lhs;
      logic [OUT_W-1:0] rhs;
      if (2 * J >= COUNT) begin : fromLeaf
        assign lhs = leaf[2*J-COUNT];
        assign rhs = leaf[2*J+1-COUNT];
      end else begin : fromNode
        assign lhs = node[2*J];
        assign rhs = node[2*J+1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) node[J] <= '0;
        else       node[J] <= lhs + (rhs << SH);
      end
    end
  end

  assign rootOut = node[1];
endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
  import da_fir_pkg::*;
#(
  parameter int LATENCY = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      coefLoad,
  output dpStrobe_t stb,
  output logic      outValid
);
  logic [LATENCY:0] vldQ;

  always_comb begin
    stb.shiftIn = inValid;
    stb.loadTbl = coefLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldQ <= '0;
    else       vldQ <= {vldQ[LATENCY-1:0], inValid};
  end

  assign outValid = vldQ[LATENCY];
endmodule

// File: rtl/da_datapath.sv
module da_datapath
  import da_fir_pkg::*;
#(
  parameter int TAPS_PER_GRP = 2,
  parameter int NUM_GRPS     = 8,
  parameter int SAMPLE_W     = 8,
  parameter int COEF_W       = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dpStrobe_t                            stb,
  input  logic [SAMPLE_W-1:0]                  inSample,
  input  logic [TAPS_PER_GRP*NUM_GRPS*COEF_W-1:0] coefIn,
  output logic [COEF_W+$clog2(TAPS_PER_GRP*NUM_GRPS)+SAMPLE_W-1:0] yOut
);
  localparam int NUM_TAPS = TAPS_PER_GRP * NUM_GRPS;
  localparam int ENTRIES  = (1 << TAPS_PER_GRP) - 1;
  localparam int TBL_W    = COEF_W + $clog2(TAPS_PER_GRP);
  localparam int SLICE_W  = TBL_W + $clog2(NUM_GRPS);
  localparam int Y_W      = COEF_W + $clog2(NUM_TAPS) + SAMPLE_W;

  // delay line, taps[0] newest
  logic [SAMPLE_W-1:0] taps [NUM_TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) taps[k] <= '0;
    end else if (stb.shiftIn) begin
      taps[0] <= inSample;
      for (int k = 1; k < NUM_TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  // subset-sum tables, one bank per group, entry 0 is implicit zero
  logic [TBL_W-1:0] tblD [NUM_GRPS][1:ENTRIES];
  logic [TBL_W-1:0] tbl  [NUM_GRPS][1:ENTRIES];

  always_comb begin
    for (int p = 0; p < NUM_GRPS; p++) begin
      for (int a = 1; a <= ENTRIES; a++) begin
        tblD[p][a] = '0;
        for (int m = 0; m < TAPS_PER_GRP; m++) begin
          if (a[m]) tblD[p][a] = tblD[p][a] + TBL_W'(coefIn[(p*TAPS_PER_GRP+m)*COEF_W +: COEF_W]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_GRPS; p++)
        for (int a = 1; a <= ENTRIES; a++) tbl[p][a] <= '0;
    end else if (stb.loadTbl) begin
      for (int p = 0; p < NUM_GRPS; p++)
        for (int a = 1; a <= ENTRIES; a++) tbl[p][a] <= tblD[p][a];
    end
  end

  // one multiplexer per bit slice per group, all reading the same bank
  logic [NUM_GRPS*TBL_W-1:0] ppD [SAMPLE_W];
  logic [NUM_GRPS*TBL_W-1:0] ppQ [SAMPLE_W];

  always_comb begin
    for (int l = 0; l < SAMPLE_W; l++) begin
      for (int p = 0; p < NUM_GRPS; p++) begin
        logic [TAPS_PER_GRP-1:0] sel;
        for (int m = 0; m < TAPS_PER_GRP; m++) sel[m] = taps[p*TAPS_PER_GRP+m][l];
        ppD[l][p*TBL_W +: TBL_W] = (sel == '0) ? '0 : tbl[p][sel];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < SAMPLE_W; l++) ppQ[l] <= '0;
    end else begin
      for (int l = 0; l < SAMPLE_W; l++) ppQ[l] <= ppD[l];
    end
  end

  // per-slice group sums, then weighted combination of slices
  logic [SAMPLE_W*SLICE_W-1:0] sliceBus;

  for (genvar l = 0; l < SAMPLE_W; l++) begin : slice
    da_add_tree #(
      .COUNT(NUM_GRPS), .IN_W(TBL_W), .OUT_W(SLICE_W), .WEIGHTED(0)
    ) uGrpSum (
      .clk(clk), .rstN(rstN), .leafIn(ppQ[l]),
      .rootOut(sliceBus[l*SLICE_W +: SLICE_W])
    );
  end

  da_add_tree #(
    .COUNT(SAMPLE_W), .IN_W(SLICE_W), .OUT_W(Y_W), .WEIGHTED(1)
  ) uBitSum (
    .clk(clk), .rstN(rstN), .leafIn(sliceBus), .rootOut(yOut)
  );
endmodule

// File: rtl/da_fir_shared_lut.sv
module da_fir_shared_lut
  import da_fir_pkg::*;
#(
  parameter int TAPS_PER_GRP = 2,
  parameter int NUM_GRPS     = 8,
  parameter int SAMPLE_W     = 8,
  parameter int COEF_W       = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    inValid,
  input  logic [SAMPLE_W-1:0]                     inSample,
  input  logic                                    coefLoad,
  input  logic [TAPS_PER_GRP*NUM_GRPS*COEF_W-1:0] coefIn,
  output logic                                    outValid,
  output logic [COEF_W+$clog2(TAPS_PER_GRP*NUM_GRPS)+SAMPLE_W-1:0] yOut
);
  localparam int LATENCY = 1 + $clog2(NUM_GRPS) + $clog2(SAMPLE_W);

  dpStrobe_t stb;

  da_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coefLoad(coefLoad),
    .stb(stb), .outValid(outValid)
  );

  da_datapath #(
    .TAPS_PER_GRP(TAPS_PER_GRP), .NUM_GRPS(NUM_GRPS),
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .inSample(inSample),
    .coefIn(coefIn), .yOut(yOut)
  );
endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int TAPS_PER_GRP = 2,
  parameter int NUM_GRPS     = 8,
  parameter int SAMPLE_W     = 8,
  parameter int COEF_W       = 8
) (
  input logic                                    clk,
  input logic                                    rstN,
  input logic                                    inValid,
  input logic                                    coefLoad,
  input logic [TAPS_PER_GRP*NUM_GRPS*COEF_W-1:0] coefIn,
  input logic                                    outValid,
  input logic [COEF_W+$clog2(TAPS_PER_GRP*NUM_GRPS)+SAMPLE_W-1:0] yOut
);
  localparam int NUM_TAPS = TAPS_PER_GRP * NUM_GRPS;
  localparam int LAT      = 1 + $clog2(NUM_GRPS) + $clog2(SAMPLE_W);
  localparam longint MAXY = longint'(NUM_TAPS) * ((longint'(1) << COEF_W) - 1)
                            * ((longint'(1) << SAMPLE_W) - 1);
  localparam int CW = $clog2(LAT + 2);

  logic [LAT:0]  seenQ;
  logic          anyQ;
  logic          zeroQ;
  logic [CW-1:0] sinceQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ  <= '0;
      anyQ   <= 1'b0;
      zeroQ  <= 1'b1;
      sinceQ <= CW'(LAT);
    end else begin
      seenQ <= {seenQ[LAT-1:0], inValid};
      if (inValid) anyQ <= 1'b1;
      if (coefLoad) begin
        zeroQ  <= (coefIn == '0);
        sinceQ <= '0;
      end else if (sinceQ < CW'(LAT)) begin
        sinceQ <= sinceQ + 1'b1;
      end
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == seenQ[LAT]);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (64'(yOut) <= MAXY));

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !anyQ |-> (yOut == '0));

  assert_zero_coef_R8: assert property (@(posedge clk) disable iff (!rstN)
    (zeroQ && sinceQ >= CW'(LAT)) |-> (yOut == '0));
endmodule

bind da_fir_shared_lut da_fir_checker #(
  .TAPS_PER_GRP(TAPS_PER_GRP), .NUM_GRPS(NUM_GRPS),
  .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .coefLoad(coefLoad),
  .coefIn(coefIn), .outValid(outValid), .yOut(yOut)
);

// File: tb/sim_da_fir_shared_lut.sv
module sim_da_fir_shared_lut;
  localparam int N = 16, W = 8, L = 8, LAT = 7, YW = 20;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, coefLoad = 1'b0;
  logic [L-1:0]   inSample = '0;
  logic [N*W-1:0] coefIn = '0;
  logic           outValid;
  logic [YW-1:0]  yOut;

  always #2 clk = ~clk;

  da_fir_shared_lut u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .coefLoad(coefLoad), .coefIn(coefIn), .outValid(outValid), .yOut(yOut)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  longint expVal[$];
  int     expCyc[$];
  string  expReq[$];
  logic [L-1:0]   hist [N];
  logic [N*W-1:0] modelCoef;

  function automatic longint convolve(input logic [N*W-1:0] c);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(c[k*W +: W]) * longint'(hist[k]);
    return s;
  endfunction

  function automatic logic [N*W-1:0] randCoefs();
    logic [N*W-1:0] c;
    for (int k = 0; k < N; k++) c[k*W +: W] = W'($urandom);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drives one cycle; the model follows R3, R4, R5
  task automatic drive(input bit v, input logic [L-1:0] x, input bit ld,
                       input logic [N*W-1:0] c, input string req);
    @(negedge clk);
    inValid = v; inSample = x; coefLoad = ld; coefIn = c;
    if (ld) modelCoef = c;
    if (v) begin
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      expVal.push_back(convolve(modelCoef));
      expCyc.push_back(cyc + 1 + LAT);
      expReq.push_back(req);
    end
  endtask

  // monitor: results must arrive exactly LAT edges after acceptance (R2)
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (rstN) begin
      if (expCyc.size() > 0 && expCyc[0] == cyc) begin
        check(outValid == 1'b1, {expReq[0], " valid R2"}, longint'(outValid), 1);
        check(yOut === YW'(expVal[0]), expReq[0], longint'(yOut), expVal[0]);
        void'(expVal.pop_front()); void'(expCyc.pop_front()); void'(expReq.pop_front());
      end else if (outValid) begin
        check(1'b0, "R2 unexpected valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", expVal.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] c;
    void'($urandom(32'd4242));
    for (int k = 0; k < N; k++) hist[k] = '0;
    modelCoef = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", longint'(outValid), 0);
    check(yOut == '0, "R1 reset y", longint'(yOut), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R1 idle valid", longint'(outValid), 0);
    check(yOut == '0, "R1 idle y", longint'(yOut), 0);

    // R8: zero coefficient set, random samples
    for (int i = 0; i < 12; i++) drive(1, L'($urandom), 0, randCoefs(), "R8");

    // R7: impulse through ascending coefficients, then amplitude 200
    for (int k = 0; k < N; k++) c[k*W +: W] = W'(k + 1);
    drive(0, 8'd0, 1, c, "R7");
    drive(1, 8'd1, 0, '0, "R7");
    for (int i = 0; i < N; i++) drive(1, 8'd0, 0, '0, "R7");
    drive(1, 8'd200, 0, '0, "R7");
    for (int i = 0; i < N; i++) drive(1, 8'd0, 0, '0, "R7");

    // R6: saturated coefficients and samples
    drive(1, 8'hFF, 1, {N*W{1'b1}}, "R6");
    for (int i = 0; i < N + 4; i++) drive(1, 8'hFF, 0, '0, "R6");

    // R5: reload mid stream, with the load cycle carrying a sample
    for (int i = 0; i < 6; i++) drive(1, L'($urandom), 0, randCoefs(), "R5");
    drive(1, L'($urandom), 1, randCoefs(), "R5");
    for (int i = 0; i < 6; i++) drive(1, L'($urandom), 0, randCoefs(), "R5");
    drive(0, L'($urandom), 1, randCoefs(), "R5");
    for (int i = 0; i < 6; i++) drive(1, L'($urandom), 0, randCoefs(), "R5");

    // R4: gaps with garbage on the sample input
    for (int i = 0; i < 150; i++)
      drive(($urandom % 4) != 0, L'($urandom), ($urandom % 40) == 0, randCoefs(), "R4");

    // R3: dense random streaming with occasional reloads
    drive(1, L'($urandom), 1, randCoefs(), "R3");
    for (int i = 0; i < 400; i++)
      drive(1, L'($urandom), (i % 97) == 96, randCoefs(), "R3");

    // drain
    for (int i = 0; i < LAT + 4; i++) drive(0, L'($urandom), 0, randCoefs(), "R2");
    check(expVal.size() == 0, "R2 all results delivered", expVal.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule